// File: doc/BRIEF.md
# Integer Ordering Compare and Byte-Lane Match Unit

This unit sits beside an integer datapath and produces two kinds of comparison result from a pair of 32-bit operands. The two compare operations return the difference `b - a`. Bit 31 of that difference is corrected so that it always gives the true ordering of the operands. Software can then test a single sign bit to learn whether `b` is below `a`, in either the signed or the unsigned sense. The third operation scans the four byte lanes of the operands from the most significant lane downward. It reports the 1-based position of the first lane where the two bytes are equal, or zero when no lane matches.

The operation is chosen by a 2-bit opcode that is sampled together with operand a, operand b and a valid strobe. The result is produced by combinational logic and captured in an output register. It appears one clock after the strobe, together with a result-valid pulse. Reset is synchronous and active-high.

Top module: `ordcmp_bytematch`

## Requirements
- R1: While `rst` is high at a clock edge, `res_o` and `res_valid_o` are both cleared to zero at that edge.
- R2: `res_valid_o` is high in the cycle after an edge where `in_valid_i` was high, and low after an edge where it was low.
- R3: With opcode 2'b00 (signed) or 2'b01 (unsigned), when bit 31 of a and bit 31 of b are equal, the result is `b - a` modulo 2^32, unchanged.
- R4: With opcode 2'b00 and differing operand top bits, result bits 30..0 are those of `b - a` and bit 31 is bit 31 of b; bit 31 is therefore set exactly when b < a as signed numbers.
- R5: With opcode 2'b01 and differing operand top bits, result bits 30..0 are those of `b - a` and bit 31 is bit 31 of a; bit 31 is therefore set exactly when b < a as unsigned numbers.
- R6: With opcode 2'b10, lanes are scanned in the order bits 31..24, 23..16, 15..8, 7..0. The result is 1, 2, 3 or 4 for the first scanned lane whose bytes in a and b are equal, and later matching lanes are ignored.
- R7: With opcode 2'b10 and no lane equal, the result is 0.
- R8: Opcode 2'b11 yields a result of 0.
- R9: After an edge where `in_valid_i` is low, `res_o` keeps its previous value whatever the operands and opcode are.
- R10: When `rst` and `in_valid_i` are both high at the same edge, reset wins: the result is 0 and `res_valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and opcode are valid this cycle |
| op_i | input | 2 | 00 signed compare, 01 unsigned compare, 10 byte-lane match, 11 zero |
| a_i | input | 32 | Operand a (subtrahend) |
| b_i | input | 32 | Operand b (minuend) |
| res_o | output | 32 | Registered result |
| res_valid_o | output | 1 | Result register was loaded by the previous edge |

## Verification
Two of the unit's functions can fall in the same cycle: loading a result and clearing it by reset. The bench provokes the collision by raising `rst` at the same edge as a strobed signed compare whose result would be non-zero. It then expects a zero result and a low valid in the next cycle. A second overlap is tested by changing operands and opcode while the strobe is low. This must leave the held result unchanged while the inputs move.

// File: rtl/ordcmp_pkg.sv
package ordcmp_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_SCMP = 2'b00,
    OP_UCMP = 2'b01,
    OP_BYTE = 2'b10,
    OP_NONE = 2'b11
  } cmp_op_e;

endpackage

// File: rtl/ordcmp_diff.sv
module ordcmp_diff #(
  parameter int unsigned W           = 32,
  parameter bit          SIGNED_MODE = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  localparam int unsigned MSB = W - 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] diff;
  logic         fix_bit;
  logic         signs_differ;

  // b minus a built as b + ~a + 1
  assign diff         = b_i + ~a_i + ONE;
  assign signs_differ = a_i[MSB] ^ b_i[MSB];

  generate
    if (SIGNED_MODE) begin : g_signed
      assign fix_bit = b_i[MSB];
    end else begin : g_unsigned
      assign fix_bit = a_i[MSB];
    end
  endgenerate

  assign res_o = signs_differ ? {fix_bit, diff[MSB-1:0]} : diff;

endmodule

// File: rtl/ordcmp_lane_match.sv
module ordcmp_lane_match #(
  parameter int unsigned W      = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  localparam int unsigned NUM_LANES = W / LANE_W;
  localparam int unsigned IDX_W     = $clog2(NUM_LANES + 1);

  // eq[k] is the k-th lane in scan order, k = 0 is the most significant
  logic [NUM_LANES-1:0] eq;
  logic [IDX_W-1:0]     idx;

  genvar k;
  generate
    for (k = 0; k < NUM_LANES; k++) begin : g_lane
      assign eq[k] = a_i[W-1-k*LANE_W -: LANE_W] == b_i[W-1-k*LANE_W -: LANE_W];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i + 1);
    end
  end

  assign res_o = W'(idx);

  // R6: the reported position never exceeds the lane count
  always_comb begin
    a_r6_idx_in_range: assert (idx <= IDX_W'(NUM_LANES));
  end

endmodule

// File: rtl/ordcmp_bytematch.sv
module ordcmp_bytematch
  import ordcmp_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned LANE_W_P = LANE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         res_valid_o
);

  localparam int unsigned MSB = W - 1;

  cmp_op_e      op;
  logic [W-1:0] scmp_res;
  logic [W-1:0] ucmp_res;
  logic [W-1:0] byte_res;
  logic [W-1:0] next_res;

  assign op = cmp_op_e'(op_i);

  ordcmp_diff #(.W(W), .SIGNED_MODE(1'b1)) u_scmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(scmp_res)
  );

  ordcmp_diff #(.W(W), .SIGNED_MODE(1'b0)) u_ucmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(ucmp_res)
  );

  ordcmp_lane_match #(.W(W), .LANE_W(LANE_W_P)) u_match (
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(byte_res)
  );

  always_comb begin
    unique case (op)
      OP_SCMP: next_res = scmp_res;
      OP_UCMP: next_res = ucmp_res;
      OP_BYTE: next_res = byte_res;
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) res_o <= next_res;
    end
  end

  // R1, R10: reset clears the stage even with a strobe present
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !res_valid_o);

  // R2: valid follows the strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> res_valid_o);

  // R4: signed result sign bit gives the signed ordering
  a_r4_signed_order: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b00) |=>
      (res_o[MSB] == ($signed($past(b_i)) < $signed($past(a_i)))));

  // R5: unsigned result sign bit gives the unsigned ordering
  a_r5_unsigned_order: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b01) |=>
      (res_o[MSB] == ($past(b_i) < $past(a_i))));

  // R8: reserved opcode yields zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b11) |=> (res_o == '0));

  // R9: no strobe, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(res_o) && !res_valid_o);

endmodule

// File: tb/ordcmp_bytematch_tb_top.sv
module ordcmp_bytematch_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid_i;
  logic [1:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [31:0] res_o;
  logic        res_valid_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ordcmp_bytematch dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid_i),
    .op_i       (op_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .res_o      (res_o),
    .res_valid_o(res_valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one strobed operation; outputs sampled at the negedge after the capturing edge
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 result", res_o, 32'h0);
    check("R1 valid", {31'b0, res_valid_o}, 32'h0);
  endtask

  task automatic t_same_sign;
    issue(2'b00, 32'd5, 32'd12);
    check("R3 signed b>a", res_o, 32'd7);
    check("R2 valid", {31'b0, res_valid_o}, 32'h1);
    issue(2'b00, 32'd12, 32'd5);
    check("R3 signed b<a", res_o, 32'hFFFF_FFF9);
    issue(2'b01, 32'h9000_0000, 32'h8000_0001);
    check("R3 unsigned same top", res_o, 32'hF000_0001);
  endtask

  task automatic t_signed_differ;
    issue(2'b00, 32'h0000_0001, 32'h8000_0000);
    check("R4 b neg", res_o, 32'hFFFF_FFFF);
    issue(2'b00, 32'h8000_0000, 32'h0000_0001);
    check("R4 a neg", res_o, 32'h0000_0001);
  endtask

  task automatic t_unsigned_differ;
    issue(2'b01, 32'h0000_0001, 32'h8000_0000);
    check("R5 b big", res_o, 32'h7FFF_FFFF);
    issue(2'b01, 32'hFFFF_FFFF, 32'h0000_0000);
    check("R5 a big", res_o, 32'h8000_0001);
  endtask

  task automatic t_bytes;
    issue(2'b10, 32'h1122_3344, 32'h11AA_BBCC);
    check("R6 lane1", res_o, 32'd1);
    issue(2'b10, 32'h0022_3344, 32'hFF22_FF44);
    check("R6 lane2 first wins", res_o, 32'd2);
    issue(2'b10, 32'h0102_0304, 32'hFFFF_03FF);
    check("R6 lane3", res_o, 32'd3);
    issue(2'b10, 32'h0000_0044, 32'hFFFF_FF44);
    check("R6 lane4", res_o, 32'd4);
    issue(2'b10, 32'h0102_0304, 32'h1020_3040);
    check("R7 none", res_o, 32'd0);
  endtask

  task automatic t_reserved;
    issue(2'b00, 32'd1, 32'd9);
    issue(2'b11, 32'hDEAD_BEEF, 32'h1234_5678);
    check("R8 reserved", res_o, 32'd0);
  endtask

  task automatic t_hold;
    issue(2'b00, 32'd3, 32'd10);
    @(negedge clk);
    op_i = 2'b10; a_i = 32'hAAAA_AAAA; b_i = 32'hAAAA_AAAA;
    @(negedge clk);
    check("R9 held", res_o, 32'd7);
    check("R2 no strobe", {31'b0, res_valid_o}, 32'h0);
  endtask

  task automatic t_reset_collide;
    @(negedge clk);
    op_i = 2'b00; a_i = 32'd1; b_i = 32'd100; in_valid_i = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0; rst = 1'b0;
    check("R10 result", res_o, 32'h0);
    check("R10 valid", {31'b0, res_valid_o}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; in_valid_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_same_sign();
    t_signed_differ();
    t_unsigned_differ();
    t_bytes();
    t_reserved();
    t_hold();
    t_reset_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule